// File: doc/BRIEF.md
# Posted-Write Register Bridge

This block sits between a fast bus clock domain and a slow functional clock domain that owns a bank of timer registers. Software writes those registers over the bus. Each write is handed across the clock boundary by a toggle request and acknowledge pair, with a two-flop synchronizer in each direction. In the functional domain the value lands in a register and a one-cycle update strobe is raised.

Each synchronized register has its own write-pending bit. The bit sets when the bus accepts a write and clears when the acknowledge for that register returns. Software reads all the bits in one status word. Posted mode is the reset default: a write completes on the bus at once, and a second write to a register whose bit is still set is dropped.

Posted mode can be turned off. Writes to synchronized registers then stall the bus until their value has landed. A soft-reset command clears the functional registers and the pending bits and restores posted mode. A reset-done status bit reports when the soft reset has finished.

Top module: `posted_reg_bridge`

## Requirements
- R1: The pending status word is read at address 0x34. Bit i belongs to synchronized register i: 0x24 is bit 0, 0x28 bit 1, 0x2C bit 2, 0x30 bit 3, 0x38 bit 4, and 0x48, 0x4C, 0x50, 0x54, 0x58 are bits 5 to 9. A bit becomes set in the cycle after the bus accepts a write to its register, and never without one.
- R2: An accepted value appears on `fn_regs` slice i, together with a one-cycle `fn_upd_valid` pulse that carries the index and the data. The pending bit clears only after that landing, within a few bus cycles.
- R3: In posted mode, a write to a register whose pending bit is set is dropped. The first value lands and the second never appears.
- R4: In posted mode, every write completes with `bus_ready` high in its first cycle.
- R5: Address 0x40 bit 2 reads the posted-mode flag. It is 1 after reset, and a write to 0x40 sets it from data bit 2.
- R6: In non-posted mode, a write to a synchronized register holds `bus_ready` low until its value has landed and its pending bit has cleared. It then completes.
- R7: Only one transfer is in flight at a time. Several pending registers are delivered one after another, and at most one pending bit clears per bus cycle outside a soft reset.
- R8: A write to 0x40 with data bit 1 set (for example 0x06) starts a soft reset. Address 0x14 bit 0 reads 0 for at least two bus cycles and then 1. Afterwards all `fn_regs` are zero, all pending bits are zero and posted mode is 1.
- R9: While a soft reset is in progress, writes to synchronized registers and to 0x40 complete at once and have no effect.
- R10: After reset, the pending word is 0, 0x14 bit 0 is 1 and 0x40 reads 0x4. Other addresses read 0, and writes to them set no pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_fn | input | 1 | Functional clock |
| rst_fn | input | 1 | Synchronous active-high reset, functional domain |
| bus_wr | input | 1 | Write request, held until bus_ready |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| bus_ready | output | 1 | Write completes in a cycle where this is high |
| fn_upd_valid | output | 1 | One-cycle pulse when a value lands |
| fn_upd_idx | output | IW | Index of the landed register |
| fn_upd_data | output | DW | Value that landed |
| fn_regs | output | NSYNC*DW | Functional-domain register bank, slice i is register i |

## Verification
The bench targets the following corner cases:

- **Second write to a register that is still pending.** A design that fails to drop it would deliver the second value or extend the pending window.
- **Burst of writes to scattered registers.** This exposes a transfer engine that loses a request or clears the wrong bit.
- **Non-posted write.** This catches a bridge that releases `bus_ready` before the value has landed.
- **Soft reset, including writes issued while it runs.** This catches a block that reports done at once, leaves stale functional values, or honours writes during the reset.

A pending bit that clears before its value has landed is also flagged.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
    localparam int ADDR_W_DEF = 8;
    localparam int DATA_W_DEF = 32;
    localparam int NSYNC_DEF  = 10;
    localparam int IDX_W      = $clog2(NSYNC_DEF);

    localparam logic [ADDR_W_DEF-1:0] PEND_ADDR  = 8'h34;
    localparam logic [ADDR_W_DEF-1:0] IFCTL_ADDR = 8'h40;
    localparam logic [ADDR_W_DEF-1:0] SYSST_ADDR = 8'h14;
    localparam int POSTED_BIT = 2;
    localparam int SRST_BIT   = 1;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } sync_sel_t;

    typedef enum logic [1:0] {
        SR_IDLE,
        SR_DRAIN,
        SR_WAIT
    } srst_state_t;

    // Map a byte address to a synchronized-register slot (bit order is software-visible)
    function automatic sync_sel_t decode_sync(input logic [ADDR_W_DEF-1:0] a);
        sync_sel_t s;
        s.hit = 1'b0;
        s.idx = '0;
        if (a[1:0] == 2'b00) begin
            if (a >= 8'h24 && a <= 8'h30) begin
                s.hit = 1'b1;
                s.idx = IDX_W'((a - 8'h24) >> 2);
            end else if (a == 8'h38) begin
                s.hit = 1'b1;
                s.idx = IDX_W'(4);
            end else if (a >= 8'h48 && a <= 8'h58) begin
                s.hit = 1'b1;
                s.idx = IDX_W'(32'((a - 8'h48) >> 2) + 32'd5);
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/pwb_sync2.sv
`timescale 1ns/1ps
module pwb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pwb_fn_core.sv
`timescale 1ns/1ps
module pwb_fn_core #(
    parameter int NSYNC = pwb_pkg::NSYNC_DEF,
    parameter int DW    = pwb_pkg::DATA_W_DEF,
    parameter int IW    = pwb_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_tog_a,
    input  logic [IW-1:0]     req_idx_a,
    input  logic [DW-1:0]     req_data_a,
    input  logic              srst_tog_a,
    output logic              ack_tog,
    output logic              srst_ack_tog,
    output logic              upd_valid,
    output logic [IW-1:0]     upd_idx,
    output logic [DW-1:0]     upd_data,
    output logic [NSYNC*DW-1:0] regs_flat
);
    logic [1:0]    tog_s;
    logic          req_seen_q, srst_seen_q;
    logic          req_evt, srst_evt;
    logic [DW-1:0] regs_q [NSYNC];

    pwb_sync2 #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({srst_tog_a, req_tog_a}),
        .q   (tog_s)
    );

    assign req_evt  = tog_s[0] != req_seen_q;
    assign srst_evt = tog_s[1] != srst_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen_q   <= 1'b0;
            srst_seen_q  <= 1'b0;
            ack_tog      <= 1'b0;
            srst_ack_tog <= 1'b0;
            upd_valid    <= 1'b0;
            upd_idx      <= '0;
            upd_data     <= '0;
            for (int i = 0; i < NSYNC; i++) regs_q[i] <= '0;
        end else begin
            upd_valid   <= 1'b0;
            req_seen_q  <= tog_s[0];
            srst_seen_q <= tog_s[1];
            if (srst_evt) begin
                for (int i = 0; i < NSYNC; i++) regs_q[i] <= '0;
                srst_ack_tog <= tog_s[1];
            end else if (req_evt) begin
                regs_q[req_idx_a] <= req_data_a;
                upd_valid         <= 1'b1;
                upd_idx           <= req_idx_a;
                upd_data          <= req_data_a;
                ack_tog           <= tog_s[0];
            end
        end
    end

    for (genvar g = 0; g < NSYNC; g++) begin : g_flat
        assign regs_flat[g*DW +: DW] = regs_q[g];
    end
endmodule

// File: rtl/pwb_bus_ctrl.sv
`timescale 1ns/1ps
module pwb_bus_ctrl
    import pwb_pkg::*;
#(
    parameter int NSYNC = NSYNC_DEF,
    parameter int DW    = DATA_W_DEF,
    parameter int AW    = ADDR_W_DEF,
    parameter int IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             bus_ready,
    output logic             xfer_tog,
    output logic [IW-1:0]    xfer_idx,
    output logic [DW-1:0]    xfer_data,
    output logic             srst_tog,
    input  logic             ack_tog_a,
    input  logic             srst_ack_a,
    output logic [NSYNC-1:0] pend_o,
    output logic             posted_o,
    output logic             srst_busy_o
);
    logic [NSYNC-1:0] pend_q, pend_d;
    logic [DW-1:0]    hold_q [NSYNC];
    logic             busy_q, np_issued_q, posted_q;
    logic             ack_seen_q, srst_seen_q;
    logic [1:0]       ack_s;
    srst_state_t      sr_st;
    sync_sel_t        sel;
    logic             wr_sync, pend_hit, accept_new, np_stall, srst_busy;
    logic             ifc_wr, srst_start, ack_evt, srst_evt, launch;
    logic [IW-1:0]    nxt_idx;

    pwb_sync2 #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({srst_ack_a, ack_tog_a}),
        .q   (ack_s)
    );

    assign sel        = decode_sync(bus_addr);
    assign srst_busy  = sr_st != SR_IDLE;
    assign wr_sync    = bus_wr && sel.hit;
    assign pend_hit   = sel.hit && pend_q[sel.idx];
    assign ack_evt    = ack_s[0] != ack_seen_q;
    assign srst_evt   = ack_s[1] != srst_seen_q;
    assign ifc_wr     = bus_wr && bus_addr == IFCTL_ADDR && !srst_busy;
    assign srst_start = ifc_wr && bus_wdata[SRST_BIT];
    assign accept_new = wr_sync && !srst_busy && !pend_hit && (posted_q || !np_issued_q);
    assign np_stall   = wr_sync && !posted_q && !srst_busy && !(np_issued_q && !pend_hit);
    assign bus_ready  = !np_stall;
    assign launch     = !busy_q && (pend_q != '0);

    always_comb begin
        nxt_idx = '0;
        for (int i = NSYNC - 1; i >= 0; i--)
            if (pend_q[i]) nxt_idx = IW'(i);
    end

    always_comb begin
        pend_d = pend_q;
        if (ack_evt)    pend_d[xfer_idx] = 1'b0;
        if (accept_new) pend_d[sel.idx]  = 1'b1;
        if (srst_start) pend_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            busy_q      <= 1'b0;
            np_issued_q <= 1'b0;
            posted_q    <= 1'b1;
            ack_seen_q  <= 1'b0;
            srst_seen_q <= 1'b0;
            xfer_tog    <= 1'b0;
            xfer_idx    <= '0;
            xfer_data   <= '0;
            srst_tog    <= 1'b0;
            sr_st       <= SR_IDLE;
            for (int i = 0; i < NSYNC; i++) hold_q[i] <= '0;
        end else begin
            ack_seen_q  <= ack_s[0];
            srst_seen_q <= ack_s[1];
            pend_q      <= pend_d;
            if (accept_new) hold_q[sel.idx] <= bus_wdata;
            if (ack_evt) busy_q <= 1'b0;
            if (launch) begin
                busy_q    <= 1'b1;
                xfer_idx  <= nxt_idx;
                xfer_data <= hold_q[nxt_idx];
                xfer_tog  <= !xfer_tog;
            end
            if (srst_busy)
                np_issued_q <= 1'b0;
            else if (np_issued_q) begin
                if (wr_sync && !pend_hit) np_issued_q <= 1'b0;
            end else if (accept_new && !posted_q)
                np_issued_q <= 1'b1;
            if (ifc_wr)
                posted_q <= bus_wdata[SRST_BIT] | bus_wdata[POSTED_BIT];
            case (sr_st)
                SR_IDLE:  if (srst_start) sr_st <= SR_DRAIN;
                SR_DRAIN: if (!busy_q) begin
                    srst_tog <= !srst_tog;
                    sr_st    <= SR_WAIT;
                end
                SR_WAIT:  if (srst_evt) sr_st <= SR_IDLE;
                default:  sr_st <= SR_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            PEND_ADDR:  bus_rdata[NSYNC-1:0]  = pend_q;
            IFCTL_ADDR: bus_rdata[POSTED_BIT] = posted_q;
            SYSST_ADDR: bus_rdata[0]          = !srst_busy;
            default:    bus_rdata = '0;
        endcase
    end

    assign pend_o      = pend_q;
    assign posted_o    = posted_q;
    assign srst_busy_o = srst_busy;
endmodule

// File: rtl/posted_reg_bridge.sv
`timescale 1ns/1ps
module posted_reg_bridge
    import pwb_pkg::*;
#(
    parameter int NSYNC = NSYNC_DEF,
    parameter int DW    = DATA_W_DEF,
    parameter int AW    = ADDR_W_DEF,
    localparam int IW   = $clog2(NSYNC)
) (
    input  logic                clk_bus,
    input  logic                rst_bus,
    input  logic                clk_fn,
    input  logic                rst_fn,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                bus_ready,
    output logic                fn_upd_valid,
    output logic [IW-1:0]       fn_upd_idx,
    output logic [DW-1:0]       fn_upd_data,
    output logic [NSYNC*DW-1:0] fn_regs
);
    logic             xfer_tog_w, srst_tog_w, ack_tog_w, srst_ack_w;
    logic [IW-1:0]    xfer_idx_w;
    logic [DW-1:0]    xfer_data_w;
    logic [NSYNC-1:0] pend_w;
    logic             posted_w, srst_busy_w;

    pwb_bus_ctrl #(.NSYNC(NSYNC), .DW(DW), .AW(AW), .IW(IW)) u_bus (
        .clk         (clk_bus),
        .rst         (rst_bus),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_ready   (bus_ready),
        .xfer_tog    (xfer_tog_w),
        .xfer_idx    (xfer_idx_w),
        .xfer_data   (xfer_data_w),
        .srst_tog    (srst_tog_w),
        .ack_tog_a   (ack_tog_w),
        .srst_ack_a  (srst_ack_w),
        .pend_o      (pend_w),
        .posted_o    (posted_w),
        .srst_busy_o (srst_busy_w)
    );

    pwb_fn_core #(.NSYNC(NSYNC), .DW(DW), .IW(IW)) u_fn (
        .clk          (clk_fn),
        .rst          (rst_fn),
        .req_tog_a    (xfer_tog_w),
        .req_idx_a    (xfer_idx_w),
        .req_data_a   (xfer_data_w),
        .srst_tog_a   (srst_tog_w),
        .ack_tog      (ack_tog_w),
        .srst_ack_tog (srst_ack_w),
        .upd_valid    (fn_upd_valid),
        .upd_idx      (fn_upd_idx),
        .upd_data     (fn_upd_data),
        .regs_flat    (fn_regs)
    );
endmodule

// File: rtl/pwb_checker.sv
`timescale 1ns/1ps
module pwb_checker
    import pwb_pkg::*;
#(
    parameter int NSYNC = NSYNC_DEF,
    parameter int AW    = ADDR_W_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_ready,
    input logic [NSYNC-1:0] pend,
    input logic             posted,
    input logic             srst_busy
);
    sync_sel_t sel;
    assign sel = decode_sync(bus_addr);

    for (genvar i = 0; i < NSYNC; i++) begin : g_rise
        // R1: a pending bit only rises after an accepted write to its register
        assert_pend_rise_R1: assert property (@(posedge clk) disable iff (rst)
            $rose(pend[i]) |-> $past(bus_wr && sel.hit && sel.idx == IDX_W'(i) && !srst_busy));
    end

    assert_posted_ready_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && posted) |-> bus_ready);

    assert_np_complete_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel.hit && !posted && !srst_busy && bus_ready) |-> !pend[sel.idx]);

    assert_one_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !$rose(srst_busy) |-> ($countones($past(pend) & ~pend) <= 1));

    assert_posted_restore_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(srst_busy) |-> posted);

    assert_srst_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        srst_busy |-> (pend == '0));
endmodule

bind posted_reg_bridge pwb_checker #(.NSYNC(NSYNC), .AW(AW)) u_chk (
    .clk       (clk_bus),
    .rst       (rst_bus),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_ready (bus_ready),
    .pend      (pend_w),
    .posted    (posted_w),
    .srst_busy (srst_busy_w)
);

// File: tb/tb_posted_reg_bridge.sv
`timescale 1ns/1ps
module tb_posted_reg_bridge;
    localparam int NS = 10;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int IW = $clog2(NS);

    logic clk_bus = 1'b0, clk_fn = 1'b0, rst_bus = 1'b1, rst_fn = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = 8'h34;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;
    logic          fn_upd_valid;
    logic [IW-1:0] fn_upd_idx;
    logic [DW-1:0] fn_upd_data;
    logic [NS*DW-1:0] fn_regs;

    always #5  clk_bus = ~clk_bus;
    always #18 clk_fn  = ~clk_fn;

    posted_reg_bridge #(.NSYNC(NS), .DW(DW), .AW(AW)) dut (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_fn(clk_fn), .rst_fn(rst_fn),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .fn_upd_valid(fn_upd_valid), .fn_upd_idx(fn_upd_idx),
        .fn_upd_data(fn_upd_data), .fn_regs(fn_regs)
    );

    int checks = 0, errors = 0;
    // behavioural reference model
    logic [NS-1:0] m_pend = '0, m_land = '0;
    logic [DW-1:0] m_hold [NS];
    logic [DW-1:0] m_fn   [NS];
    int            land_cnt [NS];
    bit            m_srst = 0, m_posted = 1, tb_busy = 0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input int i);
        if (i < 4)       return AW'(8'h24 + 4 * i);
        else if (i == 4) return 8'h38;
        else             return AW'(8'h48 + 4 * (i - 5));
    endfunction

    function automatic int idx_of(input logic [AW-1:0] a);
        for (int i = 0; i < NS; i++) if (addr_of(i) == a) return i;
        return -1;
    endfunction

    function automatic logic [DW-1:0] fn_of(input int i);
        return fn_regs[i*DW +: DW];
    endfunction

    // bus-side comparison on every idle clock
    always @(negedge clk_bus) begin
        #1;
        if (!rst_bus && !tb_busy && !m_srst) begin
            for (int i = 0; i < NS; i++) begin
                if (m_land[i]) begin
                    if (!bus_rdata[i]) begin
                        m_land[i] = 1'b0;
                        m_pend[i] = 1'b0;
                    end else begin
                        land_cnt[i]++;
                        if (land_cnt[i] > 10) begin
                            chk(0, "R2 pending bit did not clear after landing", DW'(bus_rdata[NS-1:0]), DW'(m_pend & ~m_land));
                            m_land[i] = 1'b0;
                            m_pend[i] = 1'b0;
                        end
                    end
                end
            end
            chk((((bus_rdata[NS-1:0] ^ m_pend) & ~m_land) == '0) && (bus_rdata[DW-1:NS] == '0),
                "R1 pending word vs model", bus_rdata, DW'(m_pend));
        end
    end

    // functional-side comparison on every functional clock
    always @(posedge clk_fn) begin
        #1;
        if (!rst_fn && !m_srst) begin
            if (fn_upd_valid) begin
                int k;
                k = int'(fn_upd_idx);
                chk(k < NS && m_pend[k] && !m_land[k], "R2 landing of a pending register", DW'(k), DW'(m_pend));
                if (k < NS) begin
                    chk(fn_upd_data == m_hold[k], "R2 landed data", fn_upd_data, m_hold[k]);
                    m_land[k]   = 1'b1;
                    land_cnt[k] = 0;
                    m_fn[k]     = fn_upd_data;
                end
                chk($countones(m_land) <= 1, "R7 single transfer in flight", DW'(m_land), 32'd1);
            end
            for (int i = 0; i < NS; i++)
                if (fn_of(i) != m_fn[i]) chk(0, "R2 functional register", fn_of(i), m_fn[i]);
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int stalls);
        int  ix;
        bit  r;
        ix = idx_of(a);
        @(negedge clk_bus);
        while (ix >= 0 && (m_land[ix] || (!m_posted && m_pend[ix]))) @(negedge clk_bus);
        tb_busy   = 1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        if (ix >= 0 && !m_posted && !m_srst) begin
            m_pend[ix] = 1'b1;
            m_hold[ix] = d;
        end
        stalls = 0;
        forever begin
            #4 r = bus_ready;
            @(posedge clk_bus);
            if (r) break;
            stalls++;
            @(negedge clk_bus);
        end
        if (ix >= 0 && !m_srst) begin
            if (m_posted) begin
                if (!m_pend[ix]) begin
                    m_pend[ix] = 1'b1;
                    m_hold[ix] = d;
                end
            end else begin
                m_pend[ix] = 1'b0;
                m_land[ix] = 1'b0;
            end
        end
        if (a == 8'h40 && !m_srst) begin
            if (d[1]) begin
                m_srst   = 1;
                m_pend   = '0;
                m_land   = '0;
                m_posted = 1;
            end else m_posted = d[2];
        end
        @(negedge clk_bus);
        bus_wr   = 1'b0;
        bus_addr = 8'h34;
        tb_busy  = 0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk_bus);
        tb_busy  = 1;
        bus_addr = a;
        #4 d = bus_rdata;
        @(negedge clk_bus);
        bus_addr = 8'h34;
        tb_busy  = 0;
    endtask

    task automatic wait_quiet();
        int n;
        n = 0;
        while ((m_pend != '0 || m_land != '0) && n < 500) begin
            @(negedge clk_bus);
            n++;
        end
        chk(n < 500, "R2 all writes landed", DW'(m_pend), 32'd0);
        repeat (3) @(posedge clk_fn);
    endtask

    initial begin
        logic [DW-1:0] v;
        int st, cnt;
        for (int i = 0; i < NS; i++) begin
            m_hold[i] = '0; m_fn[i] = '0; land_cnt[i] = 0;
        end
        repeat (6) @(posedge clk_fn);
        @(negedge clk_fn);  rst_fn  = 1'b0;
        @(negedge clk_bus); rst_bus = 1'b0;
        repeat (2) @(negedge clk_bus);

        // reset state
        bus_read(8'h34, v); chk(v == 32'h0, "R10 pending word after reset", v, 32'h0);
        bus_read(8'h40, v); chk(v == 32'h4, "R5 posted default", v, 32'h4);
        bus_read(8'h14, v); chk(v == 32'h1, "R10 reset-done after reset", v, 32'h1);
        chk(fn_regs == '0, "R10 functional bank after reset", fn_of(0), 32'h0);

        // posted single write
        bus_write(8'h24, 32'h0000_00A5, st);
        chk(st == 0, "R4 posted write completes at once", DW'(st), 32'd0);
        bus_read(8'h34, v); chk(v[0] == 1'b1, "R1 control pending bit 0", v, 32'h1);
        wait_quiet();
        chk(fn_of(0) == 32'hA5, "R2 control value landed", fn_of(0), 32'hA5);

        // second write while pending is dropped
        bus_write(8'h2C, 32'h111, st);
        bus_write(8'h2C, 32'h222, st);
        chk(st == 0, "R4 dropped write still completes at once", DW'(st), 32'd0);
        wait_quiet();
        chk(fn_of(2) == 32'h111, "R3 dropped write has no effect", fn_of(2), 32'h111);

        // burst to scattered registers
        bus_write(8'h58, 32'h9999, st);
        bus_write(8'h48, 32'h5555, st);
        bus_write(8'h28, 32'h1111, st);
        bus_write(8'h50, 32'h7777, st);
        bus_write(8'h30, 32'h3333, st);
        wait_quiet();
        chk(fn_of(9) == 32'h9999 && fn_of(5) == 32'h5555 && fn_of(1) == 32'h1111,
            "R7 burst delivered", fn_of(9), 32'h9999);
        chk(fn_of(7) == 32'h7777 && fn_of(3) == 32'h3333, "R7 burst delivered tail", fn_of(7), 32'h7777);

        // unmapped address
        bus_write(8'h1C, 32'hFFFF_FFFF, st);
        repeat (3) @(negedge clk_bus);
        bus_read(8'h34, v); chk(v == 32'h0, "R10 unmapped write sets no bit", v, 32'h0);
        bus_read(8'h1C, v); chk(v == 32'h0, "R10 unmapped read is zero", v, 32'h0);

        // non-posted mode
        bus_write(8'h40, 32'h0, st);
        bus_read(8'h40, v); chk(v == 32'h0, "R5 posted cleared", v, 32'h0);
        bus_write(8'h38, 32'hDEAD, st);
        chk(st >= 2, "R6 non-posted write stalls", DW'(st), 32'd2);
        chk(fn_of(4) == 32'hDEAD, "R6 value landed before completion", fn_of(4), 32'hDEAD);
        bus_read(8'h34, v); chk(v[4] == 1'b0, "R6 pending clear at completion", v, 32'h0);
        bus_write(8'h38, 32'hBEEF, st);
        chk(st >= 2 && fn_of(4) == 32'hBEEF, "R6 second non-posted write", fn_of(4), 32'hBEEF);
        bus_write(8'h40, 32'h4, st);
        bus_read(8'h40, v); chk(v == 32'h4, "R5 posted set again", v, 32'h4);

        // soft reset
        bus_write(8'h4C, 32'h6666, st);
        wait_quiet();
        bus_write(8'h40, 32'h6, st);
        cnt = 1;
        bus_read(8'h14, v); chk(v == 32'h0, "R8 reset-done low during soft reset", v, 32'h0);
        cnt++;
        bus_write(8'h28, 32'hABCD, st); cnt += 2;
        chk(st == 0, "R9 write during soft reset completes", DW'(st), 32'd0);
        bus_write(8'h40, 32'h0, st); cnt += 2;
        bus_read(8'h34, v); cnt++;
        chk(v == 32'h0, "R9 write during soft reset sets no bit", v, 32'h0);
        v = 32'h0;
        while (v[0] == 1'b0 && cnt < 400) begin
            bus_read(8'h14, v);
            cnt++;
        end
        chk(v[0] == 1'b1 && cnt >= 2, "R8 reset-done returns high", DW'(cnt), 32'd2);
        for (int i = 0; i < NS; i++) m_fn[i] = '0;
        m_srst = 0;
        repeat (2) @(posedge clk_fn);
        chk(fn_regs == '0, "R8 functional bank cleared", fn_of(6), 32'h0);
        bus_read(8'h40, v); chk(v == 32'h4, "R9 control write ignored, posted restored (R8)", v, 32'h4);
        bus_read(8'h34, v); chk(v == 32'h0, "R8 pending cleared", v, 32'h0);

        // operation after soft reset
        bus_write(8'h30, 32'h4242, st);
        wait_quiet();
        chk(fn_of(3) == 32'h4242 && fn_of(1) == 32'h0, "R2 landing after soft reset", fn_of(3), 32'h4242);

        repeat (5) @(negedge clk_bus);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_bus);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule